// File: doc/BRIEF.md
# Configuration Bank with Guarded Period Reload

This block holds a set of configuration words in two layers. Software reaches only the staging layer and a small control word through a simple register port. The logic that uses the configuration sees only the live layer. The live layer changes at one point only: the cycle after a control-period strobe, and only if software has first declared its staging update finished by setting a commit bit.

If a period strobe arrives while staging words have been written but the commit bit is still clear, the live layer is left alone and a sticky integrity-error flag is raised. The staged words stay pending, so a later period that finds the commit bit set loads them. After a reload the commit bit clears by itself, which forces software to declare every new update again. Reads are combinational, so software can read back any staging word and the control word in the same cycle it presents the address.

Top module: `cfg_safe_reload`

## Requirements
- R1: After a synchronous reset, staging word i and live word i both hold (i+1)*0x1011, truncated to the word width. The commit bit and the error flag are both clear.
- R2: A write to an address below NUM_REGS updates only that staging word, which reads back at that address from the next cycle. The live words are not changed by the write.
- R3: The control word sits at address NUM_REGS. Bit 0 is the commit bit: it reads back its state and a write loads it directly, so writing 0 withdraws a commit. Bit 1 reads back the error flag, and writing 1 to it clears the flag. Its other bits read 0. Addresses above NUM_REGS read 0, and writes to them have no effect.
- R4: When a period strobe arrives with the commit bit set, every live word equals the staging contents of the strobe cycle one cycle later.
- R5: A reload clears the commit bit, unless the same cycle carries a control write.
- R6: When a period strobe arrives with the commit bit clear and at least one staging write since the last reload, the live words do not change and the error flag is set in the next cycle.
- R7: After a rejected period the staged words and their pending state are kept. A later strobe with the commit bit set loads them.
- R8: A period strobe with the commit bit clear and no staging write since the last reload changes nothing and raises no error.
- R9: The error flag stays set until software clears it. If a clear and a rejected period fall in the same cycle, the flag ends up set.
- R10: A control write in the same cycle as a reload decides the commit bit: the written value wins over the automatic clear.
- R11: A staging write in the same cycle as a period strobe lands in the staging word but is not part of that period's reload. The strobe is judged on the state before the write, and the write counts as pending for the next period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for both reads and writes |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Combinational read data for `addr` |
| period_start | input | 1 | One-cycle strobe that marks the start of a control period |
| active_cfg | output | NUM_REGS*DATA_W | Live configuration, word i at bits [i*DATA_W +: DATA_W] |
| integrity_err | output | 1 | Sticky flag for a period that met a partial update |

## Verification
The assertions check the following on every cycle:
- the live layer holds still except one cycle after a committed strobe;
- a committed strobe copies the exact staging contents;
- the commit bit drops after a reload;
- the error flag never falls without a clear write;
- reads of unmapped addresses return zero.

Other behaviour needs the bench's ordered scenarios, because it depends on history that no single cycle shows:
- staged words surviving a rejection and loading later;
- withdrawing a commit;
- a strobe with no pending writes staying quiet;
- who wins when a strobe collides with a control or staging write.

// File: rtl/cfgrl_pkg.sv
package cfgrl_pkg;

    // What a given cycle does to the live layer
    typedef enum logic [1:0] {
        PERIOD_NONE   = 2'd0,
        PERIOD_LOAD   = 2'd1,
        PERIOD_REJECT = 2'd2,
        PERIOD_IDLE   = 2'd3
    } period_act_e;

    typedef struct packed {
        logic err;
        logic commit;
    } ctrl_state_t;

    localparam int CTRL_COMMIT_BIT = 0;
    localparam int CTRL_ERR_BIT    = 1;

    // Power-on value of word idx, identical in both layers
    function automatic logic [31:0] reset_word(input int unsigned idx);
        return (32'(idx) + 32'd1) * 32'h0000_1011;
    endfunction

    function automatic period_act_e classify(input logic strobe,
                                             input logic commit,
                                             input logic pending);
        if (!strobe)
            return PERIOD_NONE;
        else if (commit)
            return PERIOD_LOAD;
        else if (pending)
            return PERIOD_REJECT;
        else
            return PERIOD_IDLE;
    endfunction

endpackage

// File: rtl/cfgrl_addr_decode.sv
module cfgrl_addr_decode #(
    parameter int NUM_REGS = 4,
    parameter int ADDR_W   = 3
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_REGS-1:0] shadow_we,
    output logic              ctrl_we
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_REGS);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_we
        assign shadow_we[i] = wr_en && (addr == ADDR_W'(i));
    end

    assign ctrl_we = wr_en && (addr == CTRL_ADDR);

endmodule

// File: rtl/cfgrl_shadow_bank.sv
module cfgrl_shadow_bank #(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_REGS-1:0]          we,
    input  logic [DATA_W-1:0]            wdata,
    input  logic                         load,
    output logic [NUM_REGS*DATA_W-1:0]   shadow_flat,
    output logic                         pending
);
    import cfgrl_pkg::*;

    logic [DATA_W-1:0] word_q [NUM_REGS];
    logic              pending_q;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                word_q[i] <= DATA_W'(reset_word(i));
            else if (we[i])
                word_q[i] <= wdata;
        end
        assign shadow_flat[i*DATA_W +: DATA_W] = word_q[i];
    end

    // A write in the reload cycle belongs to the next period
    always_ff @(posedge clk) begin
        if (rst)
            pending_q <= 1'b0;
        else if (load)
            pending_q <= |we;
        else if (|we)
            pending_q <= 1'b1;
    end

    assign pending = pending_q;

endmodule

// File: rtl/cfgrl_ctrl.sv
module cfgrl_ctrl (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ctrl_we,
    input  logic                  wr_commit,
    input  logic                  wr_errclr,
    input  logic                  period_start,
    input  logic                  pending,
    output cfgrl_pkg::ctrl_state_t state,
    output cfgrl_pkg::period_act_e action
);
    import cfgrl_pkg::*;

    ctrl_state_t st_q;

    always_comb action = classify(period_start, st_q.commit, pending);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            // software write outranks the automatic clear
            if (ctrl_we)
                st_q.commit <= wr_commit;
            else if (action == PERIOD_LOAD)
                st_q.commit <= 1'b0;
            // a new fault outranks the clear request
            if (action == PERIOD_REJECT)
                st_q.err <= 1'b1;
            else if (ctrl_we && wr_errclr)
                st_q.err <= 1'b0;
        end
    end

    assign state = st_q;

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (st_q.err && !(ctrl_we && wr_errclr)) |=> st_q.err);

    assert_commit_autoclr_R5: assert property (@(posedge clk) disable iff (rst)
        (period_start && st_q.commit && !ctrl_we) |=> !st_q.commit);

endmodule

// File: rtl/cfgrl_active_bank.sv
module cfgrl_active_bank #(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load,
    input  logic [NUM_REGS*DATA_W-1:0] shadow_flat,
    output logic [NUM_REGS*DATA_W-1:0] active_flat
);
    import cfgrl_pkg::*;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_live
        logic [DATA_W-1:0] live_q;
        always_ff @(posedge clk) begin
            if (rst)
                live_q <= DATA_W'(reset_word(i));
            else if (load)
                live_q <= shadow_flat[i*DATA_W +: DATA_W];
        end
        assign active_flat[i*DATA_W +: DATA_W] = live_q;
    end

endmodule

// File: rtl/cfg_safe_reload.sv
module cfg_safe_reload #(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = $clog2(NUM_REGS + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    input  logic                       period_start,
    output logic [NUM_REGS*DATA_W-1:0] active_cfg,
    output logic                       integrity_err
);
    import cfgrl_pkg::*;

    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_REGS);

    logic [NUM_REGS-1:0]          shadow_we;
    logic                         ctrl_we;
    logic [NUM_REGS*DATA_W-1:0]   shadow_flat;
    logic                         pending;
    ctrl_state_t                  cstate;
    period_act_e                  action;
    logic                         do_load;

    cfgrl_addr_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_dec (
        .wr_en     (wr_en),
        .addr      (addr),
        .shadow_we (shadow_we),
        .ctrl_we   (ctrl_we)
    );

    cfgrl_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .ctrl_we      (ctrl_we),
        .wr_commit    (wdata[CTRL_COMMIT_BIT]),
        .wr_errclr    (wdata[CTRL_ERR_BIT]),
        .period_start (period_start),
        .pending      (pending),
        .state        (cstate),
        .action       (action)
    );

    assign do_load = (action == PERIOD_LOAD);

    cfgrl_shadow_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_shadow (
        .clk         (clk),
        .rst         (rst),
        .we          (shadow_we),
        .wdata       (wdata),
        .load        (do_load),
        .shadow_flat (shadow_flat),
        .pending     (pending)
    );

    cfgrl_active_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_active (
        .clk         (clk),
        .rst         (rst),
        .load        (do_load),
        .shadow_flat (shadow_flat),
        .active_flat (active_cfg)
    );

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (addr == ADDR_W'(i))
                rdata = shadow_flat[i*DATA_W +: DATA_W];
        end
        if (addr == CTRL_ADDR) begin
            rdata[CTRL_COMMIT_BIT] = cstate.commit;
            rdata[CTRL_ERR_BIT]    = cstate.err;
        end
    end

    assign integrity_err = cstate.err;

    assert_load_copies_R4: assert property (@(posedge clk) disable iff (rst)
        (period_start && cstate.commit) |=> (active_cfg == $past(shadow_flat)));

    assert_live_holds_R6: assert property (@(posedge clk) disable iff (rst)
        !(period_start && cstate.commit) |=> $stable(active_cfg));

    assert_reject_flags_R6: assert property (@(posedge clk) disable iff (rst)
        (period_start && !cstate.commit && pending) |=> integrity_err);

    assert_unmapped_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (addr > CTRL_ADDR) |-> (rdata == '0));

endmodule

// File: tb/tb_cfg_safe_reload.sv
module tb_cfg_safe_reload;

    localparam int NR = 4;
    localparam int DW = 16;
    localparam int AW = 3;
    localparam logic [NR*DW-1:0] DEF_ACT = 64'h4044_3033_2022_1011;

    typedef struct packed {
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          ps;
        logic [AW-1:0] chk;
        logic [DW-1:0] exp_rd;
        logic [NR*DW-1:0] exp_act;
        logic          exp_err;
        logic [7:0]    req;
    } vec_t;

    localparam int NV = 22;
    // control word at address 4: bit0 commit, bit1 error
    localparam vec_t TABLE [NV] = '{
        '{1'b1, 3'd0, 16'hAAAA, 1'b0, 3'd0, 16'hAAAA, 64'h4044_3033_2022_1011, 1'b0, 8'd2},  // R2
        '{1'b0, 3'd0, 16'h0000, 1'b1, 3'd4, 16'h0002, 64'h4044_3033_2022_1011, 1'b1, 8'd6},  // R6
        '{1'b1, 3'd4, 16'h0001, 1'b0, 3'd4, 16'h0003, 64'h4044_3033_2022_1011, 1'b1, 8'd3},  // R3
        '{1'b0, 3'd0, 16'h0000, 1'b1, 3'd4, 16'h0002, 64'h4044_3033_2022_AAAA, 1'b1, 8'd7},  // R7 R4 R5
        '{1'b1, 3'd4, 16'h0002, 1'b0, 3'd4, 16'h0000, 64'h4044_3033_2022_AAAA, 1'b0, 8'd9},  // R9
        '{1'b0, 3'd0, 16'h0000, 1'b1, 3'd4, 16'h0000, 64'h4044_3033_2022_AAAA, 1'b0, 8'd8},  // R8
        '{1'b1, 3'd3, 16'h5555, 1'b1, 3'd3, 16'h5555, 64'h4044_3033_2022_AAAA, 1'b0, 8'd11}, // R11
        '{1'b0, 3'd0, 16'h0000, 1'b1, 3'd4, 16'h0002, 64'h4044_3033_2022_AAAA, 1'b1, 8'd11}, // R11
        '{1'b1, 3'd4, 16'h0003, 1'b0, 3'd4, 16'h0001, 64'h4044_3033_2022_AAAA, 1'b0, 8'd3},  // R3
        '{1'b1, 3'd4, 16'h0001, 1'b1, 3'd4, 16'h0001, 64'h5555_3033_2022_AAAA, 1'b0, 8'd10}, // R10
        '{1'b1, 3'd1, 16'h1234, 1'b1, 3'd1, 16'h1234, 64'h5555_3033_2022_AAAA, 1'b0, 8'd11}, // R11
        '{1'b1, 3'd4, 16'h0001, 1'b0, 3'd4, 16'h0001, 64'h5555_3033_2022_AAAA, 1'b0, 8'd3},  // R3
        '{1'b0, 3'd0, 16'h0000, 1'b1, 3'd4, 16'h0000, 64'h5555_3033_1234_AAAA, 1'b0, 8'd5},  // R5
        '{1'b1, 3'd5, 16'hFFFF, 1'b0, 3'd5, 16'h0000, 64'h5555_3033_1234_AAAA, 1'b0, 8'd3},  // R3
        '{1'b1, 3'd2, 16'h0BEE, 1'b0, 3'd2, 16'h0BEE, 64'h5555_3033_1234_AAAA, 1'b0, 8'd2},  // R2
        '{1'b1, 3'd4, 16'h0001, 1'b0, 3'd4, 16'h0001, 64'h5555_3033_1234_AAAA, 1'b0, 8'd3},  // R3
        '{1'b1, 3'd4, 16'h0000, 1'b0, 3'd4, 16'h0000, 64'h5555_3033_1234_AAAA, 1'b0, 8'd3},  // R3
        '{1'b0, 3'd0, 16'h0000, 1'b1, 3'd4, 16'h0002, 64'h5555_3033_1234_AAAA, 1'b1, 8'd6},  // R6
        '{1'b1, 3'd4, 16'h0002, 1'b1, 3'd4, 16'h0002, 64'h5555_3033_1234_AAAA, 1'b1, 8'd9},  // R9
        '{1'b1, 3'd4, 16'h0001, 1'b0, 3'd4, 16'h0003, 64'h5555_3033_1234_AAAA, 1'b1, 8'd7},  // R7
        '{1'b0, 3'd0, 16'h0000, 1'b1, 3'd4, 16'h0002, 64'h5555_0BEE_1234_AAAA, 1'b1, 8'd7},  // R7
        '{1'b0, 3'd0, 16'h0000, 1'b0, 3'd3, 16'h5555, 64'h5555_0BEE_1234_AAAA, 1'b1, 8'd2}   // R2
    };

    logic             clk = 1'b0;
    logic             rst;
    logic             wr_en;
    logic [AW-1:0]    addr;
    logic [DW-1:0]    wdata;
    logic [DW-1:0]    rdata;
    logic             period_start;
    logic [NR*DW-1:0] active_cfg;
    logic             integrity_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    cfg_safe_reload #(.NUM_REGS(NR), .DATA_W(DW)) dut (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (wr_en),
        .addr          (addr),
        .wdata         (wdata),
        .rdata         (rdata),
        .period_start  (period_start),
        .active_cfg    (active_cfg),
        .integrity_err (integrity_err)
    );

    task automatic check(input string what, input int req,
                         input logic [NR*DW-1:0] act, input logic [NR*DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    task automatic peek(input logic [AW-1:0] a);
        addr = a;
        #1;
    endtask

    task automatic check_defaults(input string tag);
        for (int i = 0; i < NR; i++) begin
            peek(AW'(i));
            check({tag, " staging word"}, 1, {48'h0, rdata}, {48'h0, DEF_ACT[i*DW +: DW]}); // R1
        end
        peek(3'd4);
        check({tag, " control word"}, 1, {48'h0, rdata}, 64'h0);
        check({tag, " live words"}, 1, active_cfg, DEF_ACT);
        check({tag, " error flag"}, 1, {63'h0, integrity_err}, 64'h0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; addr = '0; wdata = '0; period_start = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_defaults("reset");

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            wr_en        = TABLE[v].wr;
            addr         = TABLE[v].addr;
            wdata        = TABLE[v].wdata;
            period_start = TABLE[v].ps;
            @(posedge clk);
            #3;
            wr_en = 1'b0;
            period_start = 1'b0;
            peek(TABLE[v].chk);
            check($sformatf("vec %0d read", v), TABLE[v].req, {48'h0, rdata}, {48'h0, TABLE[v].exp_rd});
            check($sformatf("vec %0d live", v), TABLE[v].req, active_cfg, TABLE[v].exp_act);
            check($sformatf("vec %0d error", v), TABLE[v].req, {63'h0, integrity_err}, {63'h0, TABLE[v].exp_err});
        end

        // R1: reset in mid run restores both layers
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_defaults("re-reset");

        // R8: a strobe right after reset must stay quiet
        @(negedge clk);
        period_start = 1'b1;
        @(posedge clk);
        #3;
        period_start = 1'b0;
        check("quiet strobe live", 8, active_cfg, DEF_ACT);
        check("quiet strobe error", 8, {63'h0, integrity_err}, 64'h0);

        finish_run();
    end

endmodule